// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Controller

This block owns the interrupt state of a serial peripheral interface whose transmit and receive paths may be buffered by small FIFOs. The FIFO logic reports its state to the block through level inputs and event strobes. The levels are receive data ready, transmit empty, transmit nearly empty, receive nearly full, both full indications and both entry counts. The strobes are a receive arrival and a write of the transmit data register. From these the block keeps overflow and error flags and drives one transmit and one receive interrupt line.

Software uses a small register port with two addresses. Address 0 is a control register. It holds the clear-mechanism select, the two FIFO-threshold interrupt enables, the FIFO-mode bit and the two general interrupt enables. Address 1 is the clear register. Its upper nibble shows the error and overflow flags, and these flags clear when they are read. Its lower nibble takes write-one strobes that acknowledge the four interrupt sources, and it always reads as zero. Each interrupt source can be acknowledged in one of two ways. In level mode it follows the FIFO state. In acknowledge mode it latches on a rising flag and is released only by software.

If a FIFO ever reports more entries than its depth, the block records an error for that direction. It also pulses a flush request and wipes every other status flag and pending interrupt.

Top module: `spi_irq_ctrl`

## Requirements
- R1: The receive overflow flag (clear-register bit 4) sets when `ev_rx_data` is high while `rx_full` is high. The transmit overflow flag (bit 5) sets when `ev_tx_write` is high while `tx_full` is high. A strobe with the matching full input low sets nothing.
- R2: A read at address 1 returns the flags in bits 7:4, ordered {tx_err, rx_err, tx_ovf, rx_ovf}. Each flag that is set at that read clears. If a setting event for a flag arrives in the same cycle as the read, that flag stays set.
- R3: Bits 3:0 of a read at address 1 are always 0.
- R4: With control bit 0 (clear select) at 0, each interrupt source pending state follows its input level. A write-one to a clear bit has no effect.
- R5: With control bit 0 at 1, a source becomes pending on a 0-to-1 change of its input. Writing 1 at address 1 clears it, even while the input stays high. The clear bits are: bit 0 receive ready, bit 1 transmit empty, bit 2 receive nearly full, bit 3 transmit nearly empty.
- R6: `irq_tx` is high only when the transmit enable (control bit 4) is set and one of two sources is pending. One is transmit empty. The other is transmit nearly empty, with its enable (bit 1) and FIFO mode (bit 3) both set.
- R7: `irq_rx` is high only when the receive enable (control bit 5) is set and one of two sources is pending. One is receive ready. The other is receive nearly full, with its enable (bit 2) and FIFO mode (bit 3) both set.
- R8: With FIFO mode at 0, the nearly-empty and nearly-full enables have no effect on either interrupt line.
- R9: A count above DEPTH (default 8) has these effects. The FIFO's error flag sets. Its flush output is high in the next cycle. Both overflow flags and all four pending sources are wiped.
- R10: After reset every flag, pending source, control bit and output is 0.
- R11: A read at address 0 returns the control register in bits 5:0, and 0 in bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rx_data | input | 1 | Strobe: a receive word arrived |
| ev_tx_write | input | 1 | Strobe: transmit data register written |
| rx_full | input | 1 | Receive FIFO full |
| tx_full | input | 1 | Transmit FIFO full |
| rx_ready | input | 1 | Receive data available level |
| tx_empty | input | 1 | Transmit buffer empty level |
| rx_near_full | input | 1 | Receive FIFO nearly full level |
| tx_near_empty | input | 1 | Transmit FIFO nearly empty level |
| rx_count | input | CNT_W | Receive FIFO entry count |
| tx_count | input | CNT_W | Transmit FIFO entry count |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 clear |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| flush_rx | output | 1 | Receive FIFO flush request |
| flush_tx | output | 1 | Transmit FIFO flush request |

## Verification
The assertions assume that strobes and levels are synchronous to `clk` and that `bus_rd` and `bus_wr` are never high together. They also assume that an event strobe lasts one cycle per event. The stimulus drives every input at the falling edge. It issues reads and writes through tasks that never overlap. In the random phase, the counts stay within the FIFO depth, so that the overflow model is not disturbed by error wipes. Those wipes are exercised only in directed cases.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  // Control register, bit 0 is clr_w1c
  typedef struct packed {
    logic rx_ie;
    logic tx_ie;
    logic fifo_mode;
    logic nf_en;
    logic ne_en;
    logic clr_w1c;
  } ctrl_t;

  localparam int NSRC   = 4;  // interrupt sources
  localparam int NFLAG  = 4;  // clear-on-read flags
  localparam int SRC_RX_RDY = 0;
  localparam int SRC_TX_EMP = 1;
  localparam int SRC_RX_NF  = 2;
  localparam int SRC_TX_NE  = 3;
  localparam int FL_RX_OVF  = 0;
  localparam int FL_TX_OVF  = 1;
  localparam int FL_RX_ERR  = 2;
  localparam int FL_TX_ERR  = 3;
endpackage

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] wipe,
  input  logic [N-1:0] rd_clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            q[i] <= 1'b0;
      else if (wipe[i])   q[i] <= 1'b0;
      else if (set[i])    q[i] <= 1'b1;
      else if (rd_clr[i]) q[i] <= 1'b0;
    end

    // R2: a setting event in the read cycle keeps the flag
    a_r2_set_wins: assert property (@(posedge clk) disable iff (rst)
      (set[i] && !wipe[i]) |=> q[i]);
    // R2: a read of a set flag with no new event clears it
    a_r2_read_clears: assert property (@(posedge clk) disable iff (rst)
      (rd_clr[i] && q[i] && !set[i]) |=> !q[i]);
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         w1c_mode,
  input  logic         wipe,
  input  logic [N-1:0] level,
  input  logic [N-1:0] w1c,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise;
    assign rise = level[i] & ~prev[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i] <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        prev[i] <= level[i];
        if (wipe)          pend[i] <= 1'b0;
        else if (!w1c_mode) pend[i] <= level[i];
        else if (rise)     pend[i] <= 1'b1;
        else if (w1c[i])   pend[i] <= 1'b0;
      end
    end

    // R5: acknowledge clears a pending source when no new edge arrives
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
      (w1c_mode && w1c[i] && !rise) |=> !pend[i]);
    // R9: a wipe leaves nothing pending
    a_r9_wipe: assert property (@(posedge clk) disable iff (rst)
      wipe |=> !pend[i]);
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_rx_data,
  input  logic             ev_tx_write,
  input  logic             rx_full,
  input  logic             tx_full,
  input  logic             rx_ready,
  input  logic             tx_empty,
  input  logic             rx_near_full,
  input  logic             tx_near_empty,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [5:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             flush_rx,
  output logic             flush_tx
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

  ctrl_t            ctrl;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] fl_set, fl_wipe, fl_rd;
  logic [NSRC-1:0]  pend, src_level, ack;
  logic             err_rx, err_tx, wipe, rd_clr_reg, wr_clr_reg;

  assign err_rx     = rx_count > LIMIT;
  assign err_tx     = tx_count > LIMIT;
  assign wipe       = err_rx | err_tx;
  assign rd_clr_reg = bus_rd & bus_addr;
  assign wr_clr_reg = bus_wr & bus_addr;

  // Control register
  always_ff @(posedge clk) begin
    if (rst)                    ctrl <= '0;
    else if (bus_wr && !bus_addr) ctrl <= ctrl_t'(bus_wdata);
  end

  // Clear-on-read flags
  always_comb begin
    fl_set             = '0;
    fl_set[FL_RX_OVF]  = ev_rx_data & rx_full;
    fl_set[FL_TX_OVF]  = ev_tx_write & tx_full;
    fl_set[FL_RX_ERR]  = err_rx;
    fl_set[FL_TX_ERR]  = err_tx;
    fl_wipe            = '0;
    fl_wipe[FL_RX_OVF] = wipe;
    fl_wipe[FL_TX_OVF] = wipe;
    fl_rd              = {NFLAG{rd_clr_reg}} & flags;
  end

  sticky_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(fl_set), .wipe(fl_wipe), .rd_clr(fl_rd), .q(flags)
  );

  // Interrupt sources
  always_comb begin
    src_level             = '0;
    src_level[SRC_RX_RDY] = rx_ready;
    src_level[SRC_TX_EMP] = tx_empty;
    src_level[SRC_RX_NF]  = rx_near_full;
    src_level[SRC_TX_NE]  = tx_near_empty;
    ack                   = bus_wdata[NSRC-1:0] & {NSRC{wr_clr_reg}};
  end

  irq_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst), .w1c_mode(ctrl.clr_w1c), .wipe(wipe),
    .level(src_level), .w1c(ack), .pend(pend)
  );

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx    <= 1'b0;
      irq_rx    <= 1'b0;
      flush_rx  <= 1'b0;
      flush_tx  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_tx   <= ctrl.tx_ie & (pend[SRC_TX_EMP] |
                  (ctrl.fifo_mode & ctrl.ne_en & pend[SRC_TX_NE]));
      irq_rx   <= ctrl.rx_ie & (pend[SRC_RX_RDY] |
                  (ctrl.fifo_mode & ctrl.nf_en & pend[SRC_RX_NF]));
      flush_rx <= err_rx;
      flush_tx <= err_tx;
      if (bus_rd) bus_rdata <= bus_addr ? {flags, 4'b0000} : {2'b00, ctrl};
    end
  end

  // R1: overflow capture
  a_r1_rx_ovf: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_data && rx_full && !wipe) |=> flags[FL_RX_OVF]);
  a_r1_tx_ovf: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_write && tx_full && !wipe) |=> flags[FL_TX_OVF]);
  // R3: acknowledge bits read as zero
  a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr) |=> bus_rdata[3:0] == 4'b0000);
  // R6 / R7: no interrupt without the general enable
  a_r6_tx_gate: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> $past(ctrl.tx_ie));
  a_r7_rx_gate: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> $past(ctrl.rx_ie));
  // R9: occupancy fault raises error and flush
  a_r9_rx_err: assert property (@(posedge clk) disable iff (rst)
    err_rx |=> (flags[FL_RX_ERR] && flush_rx));
  a_r9_tx_err: assert property (@(posedge clk) disable iff (rst)
    err_tx |=> (flags[FL_TX_ERR] && flush_tx));
endmodule

// File: tb/sim_spi_irq_ctrl.sv
module sim_spi_irq_ctrl;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_rx_data = 0, ev_tx_write = 0, rx_full = 0, tx_full = 0;
  logic rx_ready = 0, tx_empty = 0, rx_near_full = 0, tx_near_empty = 0;
  logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [5:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_tx, irq_rx, flush_rx, flush_tx;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;  // 250 MHz

  spi_irq_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .ev_rx_data(ev_rx_data), .ev_tx_write(ev_tx_write),
    .rx_full(rx_full), .tx_full(tx_full), .rx_ready(rx_ready), .tx_empty(tx_empty),
    .rx_near_full(rx_near_full), .tx_near_empty(tx_near_empty),
    .rx_count(rx_count), .tx_count(tx_count), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .flush_rx(flush_rx), .flush_tx(flush_tx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [5:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rdr(input logic a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_rx_ovf();
    @(negedge clk); ev_rx_data = 1; rx_full = 1;
    @(negedge clk); ev_rx_data = 0; rx_full = 0;
  endtask

  // Model of the overflow nibble for the random phase (R1, R2)
  function automatic logic [1:0] ovf_next(input logic [1:0] m, input logic snap_rd,
                                          input logic er, input logic rf,
                                          input logic et, input logic tf);
    logic [1:0] s;
    s = snap_rd ? m : 2'b00;
    return (m & ~s) | {et & tf, er & rf};
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] model;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;

    // R10 reset state
    @(negedge clk);
    chk({irq_tx, irq_rx, flush_rx, flush_tx} == 4'b0, "R10 outputs", {irq_tx, irq_rx, flush_rx, flush_tx}, 0);
    rdr(1'b1, rd); chk(rd == 8'h00, "R10 clear reg", rd, 8'h00);
    rdr(1'b0, rd); chk(rd == 8'h00, "R10 control", rd, 8'h00);

    // R11 control readback
    wr(1'b0, 6'h2D); rdr(1'b0, rd); chk(rd == 8'h2D, "R11 readback", rd, 8'h2D);
    wr(1'b0, 6'h00);

    // R1 / R2 overflow and clear-on-read
    pulse_rx_ovf();
    rdr(1'b1, rd); chk(rd == 8'h10, "R1 rx ovf", rd, 8'h10);
    rdr(1'b1, rd); chk(rd == 8'h00, "R2 cleared by read", rd, 8'h00);
    @(negedge clk); ev_tx_write = 1; tx_full = 1;
    @(negedge clk); ev_tx_write = 0; tx_full = 0;
    rdr(1'b1, rd); chk(rd == 8'h20, "R1 tx ovf", rd, 8'h20);
    @(negedge clk); ev_rx_data = 1; ev_tx_write = 1;
    @(negedge clk); ev_rx_data = 0; ev_tx_write = 0;
    rdr(1'b1, rd); chk(rd == 8'h00, "R1 no ovf when not full", rd, 8'h00);

    // R2 event in the read cycle survives
    pulse_rx_ovf();
    @(negedge clk); bus_rd = 1; bus_addr = 1; ev_rx_data = 1; rx_full = 1;
    @(negedge clk); bus_rd = 0; ev_rx_data = 0; rx_full = 0;
    chk(bus_rdata == 8'h10, "R2 snapshot", bus_rdata, 8'h10);
    rdr(1'b1, rd); chk(rd == 8'h10, "R2 set wins over read", rd, 8'h10);
    chk(rd[3:0] == 4'h0, "R3 low nibble zero", rd[3:0], 0);
    rdr(1'b1, rd); chk(rd == 8'h00, "R2 then clears", rd, 8'h00);

    // R5 acknowledge mode
    wr(1'b0, 6'h11);
    tx_empty = 1; settle();
    chk(irq_tx == 1, "R5 edge sets pending", irq_tx, 1);
    wr(1'b1, 6'h02); settle();
    chk(irq_tx == 0, "R5 ack clears with level high", irq_tx, 0);
    rdr(1'b1, rd); chk(rd[3:0] == 4'h0, "R3 ack bits read zero", rd[3:0], 0);
    tx_empty = 0; settle(); tx_empty = 1; settle();
    chk(irq_tx == 1, "R5 new edge sets again", irq_tx, 1);

    // R4 level mode
    wr(1'b0, 6'h10); settle();
    chk(irq_tx == 1, "R4 follows level", irq_tx, 1);
    wr(1'b1, 6'h0F); settle();
    chk(irq_tx == 1, "R4 ack ignored", irq_tx, 1);
    tx_empty = 0; settle();
    chk(irq_tx == 0, "R4 level low clears", irq_tx, 0);

    // R7 receive line and enable
    wr(1'b0, 6'h20); rx_ready = 1; settle();
    chk(irq_rx == 1, "R7 rx ready", irq_rx, 1);
    wr(1'b0, 6'h00); settle();
    chk(irq_rx == 0, "R7 needs rx enable", irq_rx, 0);
    rx_ready = 0;

    // R8 / R6 nearly-empty path
    tx_near_empty = 1; wr(1'b0, 6'h12); settle();
    chk(irq_tx == 0, "R8 ne enable ignored without fifo mode", irq_tx, 0);
    wr(1'b0, 6'h1A); settle();
    chk(irq_tx == 1, "R6 nearly empty", irq_tx, 1);
    wr(1'b0, 6'h0A); settle();
    chk(irq_tx == 0, "R6 needs tx enable", irq_tx, 0);
    tx_near_empty = 0;

    // R8 / R7 nearly-full path
    rx_near_full = 1; wr(1'b0, 6'h24); settle();
    chk(irq_rx == 0, "R8 nf enable ignored without fifo mode", irq_rx, 0);
    wr(1'b0, 6'h2C); settle();
    chk(irq_rx == 1, "R7 nearly full", irq_rx, 1);
    rx_near_full = 0; wr(1'b0, 6'h00); settle();

    // R9 occupancy fault
    @(negedge clk); ev_tx_write = 1; tx_full = 1;
    @(negedge clk); ev_tx_write = 0; tx_full = 0;
    @(negedge clk); tx_count = CNT_W'(DEPTH + 1);
    @(negedge clk); chk(flush_tx == 1, "R9 flush pulse", flush_tx, 1); tx_count = '0;
    @(negedge clk); chk(flush_tx == 0, "R9 flush ends", flush_tx, 0);
    rdr(1'b1, rd); chk(rd == 8'h80, "R9 error set, ovf wiped", rd, 8'h80);
    rdr(1'b1, rd); chk(rd == 8'h00, "R2 error clears on read", rd, 8'h00);
    wr(1'b0, 6'h11); tx_empty = 1; settle();
    chk(irq_tx == 1, "R5 pending before fault", irq_tx, 1);
    @(negedge clk); rx_count = CNT_W'(DEPTH + 3);
    @(negedge clk); rx_count = '0; settle();
    chk(irq_tx == 0, "R9 pending wiped", irq_tx, 0);
    rdr(1'b1, rd); chk(rd == 8'h40, "R9 rx error", rd, 8'h40);
    tx_empty = 0; wr(1'b0, 6'h00);

    // R1 / R2 random phase
    model = 2'b00;
    for (int i = 0; i < 400; i++) begin
      logic r, er, rf, et, tf;
      r  = ($urandom % 5) == 0;
      er = ($urandom % 3) == 0;
      rf = ($urandom % 2) == 0;
      et = ($urandom % 3) == 0;
      tf = ($urandom % 2) == 0;
      @(negedge clk);
      bus_rd = r; bus_addr = 1; ev_rx_data = er; rx_full = rf;
      ev_tx_write = et; tx_full = tf;
      @(negedge clk);
      bus_rd = 0; ev_rx_data = 0; ev_tx_write = 0;
      if (r) chk(bus_rdata == {2'b00, model, 4'b0000}, "R1 R2 random",
                 bus_rdata, {2'b00, model, 4'b0000});
      model = ovf_next(model, r, er, rf, et, tf);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule